// File: doc/BRIEF.md
# Page-Write Polling Host Controller

This block is a bus master that sits between an internal request port and an external byte-wide electrically erasable memory. It writes one byte or a burst of up to 64 bytes into a single page of that memory. It then reads status back from the device until the device reports that its internal programming has finished, and ends with a one-cycle completion pulse. All bus timing is set in clock cycles by parameters, so each phase can be sized to meet the device's minimum pulse widths and delays at the chosen clock rate.

A request carries a start address, a byte count minus one and a completion method. Each byte of a burst comes from the requester: the controller shows the index of the byte it wants, and the requester answers in the same cycle. Two completion methods are offered. The first reads the last written location and waits until its top data bit matches the top bit that was written. The second compares the next-to-top bit across two back-to-back reads and stops when they agree. A timeout ends the polling with an error flag instead of a success.

Top module: `nvm_poll_writer`

## Requirements
- R1: While reset is applied, and after it until the first request, CE, OE and WE are high, the data driver is off, `reqReady` is 1 and `doneValid` is 0.
- R2: A request is taken on a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` then stays 0 until the cycle after the `doneValid` pulse.
- R3: A request writes `reqLen`+1 bytes. Byte i goes to the address whose bits 12..6 equal those of `reqAddr` and whose bits 5..0 equal (`reqAddr`[5:0] + i) mod 64. The byte is the value of `byteData` while `byteIdx` equals i.
- R4: Each byte load holds WE low for exactly `WeLowCyc` cycles, with CE low throughout. Within a burst, successive WE falling edges are exactly `WeLowCyc`+`LoadGapCyc`+1 cycles apart.
- R5: The data driver enable is 1 only while WE is low, and OE is high whenever WE is low.
- R6: The first status read starts only after WE has been high for at least `PollWaitCyc` cycles following the last byte load.
- R7: Each status read holds CE and OE low for exactly `ReadCyc` cycles at the last written address, and `memDin` is sampled on the final edge of that window.
- R8: With `reqMode`=0, polling ends with success on the first read whose bit 7 equals bit 7 of the last written byte.
- R9: With `reqMode`=1, polling ends with success on the first read whose bit 6 equals bit 6 of the read just before it. At least two reads are made.
- R10: If polling has not succeeded once `TimeoutCyc` cycles have passed since polling began, the request ends with `doneErr`=1.
- R11: `doneValid` is a single-cycle pulse. `doneErr` is 0 with it on success.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller idle, request can be taken |
| reqAddr | input | 13 | Start address of the burst |
| reqLen | input | 6 | Byte count minus one |
| reqMode | input | 1 | 0: top-bit compare, 1: toggle compare |
| byteIdx | output | 6 | Index of the byte being fetched |
| byteData | input | 8 | Byte for index `byteIdx` |
| doneValid | output | 1 | Request finished (one cycle) |
| doneErr | output | 1 | Finished by timeout |
| memAddr | output | 13 | Memory address bus |
| memDout | output | 8 | Data toward memory |
| memDin | input | 8 | Data from memory |
| memDoe | output | 1 | Enable for the data bus driver |
| memCeN | output | 1 | Chip enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |

## Verification
The assertions assume that `reqValid` is raised only while the controller is idle. They also assume that `byteData` depends only on `byteIdx` while a burst runs, and that the device answers every read with either its status bits or its true data. The bench drives requests only after a completion and feeds `byteData` from a pure function of the index. Its memory model returns status during a programming window that restarts at each WE rise. That model is forced busy in only two cases: the timeout runs in top-bit mode and in toggle mode.

// File: rtl/nvm_poll_pkg.sv
package nvm_poll_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_WLOW,
    S_WGAP,
    S_PWAIT,
    S_RLOW,
    S_RGAP,
    S_FIN
  } phase_e;

  typedef struct packed {
    logic captReq;
    logic loadByte;
    logic nextIdx;
    logic captRead;
  } dpStrobe_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nvm_poll_datapath.sv
module nvm_poll_datapath
  import nvm_poll_pkg::*;
#(
  parameter int AddrW = 13,
  parameter int PageW = 6,
  parameter int DataW = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        ctl,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [PageW-1:0] reqLen,
  input  logic [DataW-1:0] byteData,
  input  logic [DataW-1:0] memDin,
  output logic [AddrW-1:0] memAddr,
  output logic [DataW-1:0] memDout,
  output logic [PageW-1:0] byteIdx,
  output logic             lastByte,
  output logic             pollBitOk,
  output logic             togSame
);
  localparam int PollBit = DataW - 1;
  localparam int TogBit  = DataW - 2;

  logic [AddrW-1:0] baseAddr;
  logic [PageW-1:0] lenReg;
  logic [PageW-1:0] idx;
  logic [DataW-1:0] dataReg;
  logic [DataW-1:0] rdCur;
  logic             prevTog;
  logic [PageW-1:0] offs;
  logic [TogBit-1:0] unusedRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddr <= '0;
      lenReg   <= '0;
      idx      <= '0;
      dataReg  <= '0;
      rdCur    <= '0;
      prevTog  <= 1'b0;
    end else begin
      if (ctl.captReq) begin
        baseAddr <= reqAddr;
        lenReg   <= reqLen;
        idx      <= '0;
      end
      if (ctl.nextIdx)  idx     <= idx + 1'b1;
      if (ctl.loadByte) dataReg <= byteData;
      if (ctl.captRead) begin
        prevTog <= rdCur[TogBit];
        rdCur   <= memDin;
      end
    end
  end

  // offset wraps inside the page, page bits come only from the request
  assign offs      = baseAddr[PageW-1:0] + idx;
  assign memAddr   = {baseAddr[AddrW-1:PageW], offs};
  assign memDout   = dataReg;
  assign byteIdx   = idx;
  assign lastByte  = (idx == lenReg);
  assign pollBitOk = (rdCur[PollBit] == dataReg[PollBit]);
  assign togSame   = (rdCur[TogBit] == prevTog);
  assign unusedRd  = rdCur[TogBit-1:0];

endmodule

// File: rtl/nvm_poll_ctrl.sv
module nvm_poll_ctrl
  import nvm_poll_pkg::*;
#(
  parameter int WeLowCyc    = 6,
  parameter int LoadGapCyc  = 12,
  parameter int PollWaitCyc = 1000,
  parameter int ReadCyc     = 8,
  parameter int TimeoutCyc  = 600000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqMode,
  input  logic      lastByte,
  input  logic      pollBitOk,
  input  logic      togSame,
  output dpStrobe_t ctl,
  output logic      reqReady,
  output logic      memCeN,
  output logic      memOeN,
  output logic      memWeN,
  output logic      memDoe,
  output logic      doneValid,
  output logic      doneErr
);
  localparam int PhaseMax = maxOf(maxOf(WeLowCyc, LoadGapCyc), maxOf(PollWaitCyc, ReadCyc));
  localparam int CntW     = $clog2(PhaseMax + 1);
  localparam int TmoW     = $clog2(TimeoutCyc + 1);
  localparam int RiseW    = $clog2(PollWaitCyc + 1);

  phase_e          st;
  logic [CntW-1:0] cnt;
  logic [TmoW-1:0] tmo;
  logic            toggleMode;
  logic            havePrev;
  logic            errFlag;
  logic            cntLast;
  logic            tmoHit;
  logic            pollDone;
  logic [TmoW-1:0] tmoNext;

  always_comb begin
    unique case (st)
      S_WLOW:  cntLast = (cnt == CntW'(WeLowCyc - 1));
      S_WGAP:  cntLast = (cnt == CntW'(LoadGapCyc - 1));
      S_PWAIT: cntLast = (cnt == CntW'(PollWaitCyc - 1));
      S_RLOW:  cntLast = (cnt == CntW'(ReadCyc - 1));
      default: cntLast = 1'b0;
    endcase
  end

  assign tmoHit   = (tmo >= TmoW'(TimeoutCyc));
  assign tmoNext  = tmoHit ? tmo : tmo + 1'b1;
  assign pollDone = toggleMode ? (havePrev && togSame) : pollBitOk;

  assign ctl.captReq  = (st == S_IDLE) && reqValid;
  assign ctl.loadByte = (st == S_LOAD);
  assign ctl.nextIdx  = (st == S_WGAP) && cntLast && !lastByte;
  assign ctl.captRead = (st == S_RLOW) && cntLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st         <= S_IDLE;
      cnt        <= '0;
      tmo        <= '0;
      toggleMode <= 1'b0;
      havePrev   <= 1'b0;
      errFlag    <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: if (reqValid) begin
          st         <= S_LOAD;
          toggleMode <= reqMode;
        end
        S_LOAD: begin
          st  <= S_WLOW;
          cnt <= '0;
        end
        S_WLOW: if (cntLast) begin
          st  <= S_WGAP;
          cnt <= '0;
        end else cnt <= cnt + 1'b1;
        S_WGAP: if (cntLast) begin
          cnt <= '0;
          if (lastByte) begin
            st       <= S_PWAIT;
            tmo      <= '0;
            havePrev <= 1'b0;
          end else st <= S_LOAD;
        end else cnt <= cnt + 1'b1;
        S_PWAIT: begin
          tmo <= tmoNext;
          if (cntLast) begin
            st  <= S_RLOW;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_RLOW: begin
          tmo <= tmoNext;
          if (cntLast) begin
            st  <= S_RGAP;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_RGAP: begin
          tmo <= tmoNext;
          if (pollDone) begin
            st      <= S_FIN;
            errFlag <= 1'b0;
          end else if (tmoHit) begin
            st      <= S_FIN;
            errFlag <= 1'b1;
          end else begin
            st       <= S_RLOW;
            havePrev <= 1'b1;
          end
        end
        S_FIN:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign reqReady  = (st == S_IDLE);
  assign memWeN    = (st != S_WLOW);
  assign memOeN    = (st != S_RLOW);
  assign memCeN    = !((st == S_WLOW) || (st == S_RLOW));
  assign memDoe    = (st == S_WLOW);
  assign doneValid = (st == S_FIN);
  assign doneErr   = (st == S_FIN) && errFlag;

  // cycles with WE high since the last load, used only by the R6 check
  logic [RiseW-1:0] sinceRise;
  always_ff @(posedge clk) begin
    if (!rstN)                             sinceRise <= '0;
    else if (!memWeN)                      sinceRise <= '0;
    else if (sinceRise != RiseW'(PollWaitCyc)) sinceRise <= sinceRise + 1'b1;
  end

  a_r5_oe_high_while_we_low: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);
  a_r5_drive_only_we_low: assert property (@(posedge clk) disable iff (!rstN)
    memDoe |-> !memWeN);
  a_r6_poll_wait: assert property (@(posedge clk) disable iff (!rstN)
    (!memOeN && ctl.captRead == 1'b0 && cnt == '0) |-> sinceRise == RiseW'(PollWaitCyc));
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

endmodule

// File: rtl/nvm_poll_writer.sv
module nvm_poll_writer
  import nvm_poll_pkg::*;
#(
  parameter int AddrW       = 13,
  parameter int PageW       = 6,
  parameter int DataW       = 8,
  parameter int WeLowCyc    = 6,
  parameter int LoadGapCyc  = 12,
  parameter int PollWaitCyc = 1000,
  parameter int ReadCyc     = 8,
  parameter int TimeoutCyc  = 600000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [AddrW-1:0] reqAddr,
  input  logic [PageW-1:0] reqLen,
  input  logic             reqMode,
  output logic [PageW-1:0] byteIdx,
  input  logic [DataW-1:0] byteData,
  output logic             doneValid,
  output logic             doneErr,
  output logic [AddrW-1:0] memAddr,
  output logic [DataW-1:0] memDout,
  input  logic [DataW-1:0] memDin,
  output logic             memDoe,
  output logic             memCeN,
  output logic             memOeN,
  output logic             memWeN
);
  dpStrobe_t ctl;
  logic      lastByte;
  logic      pollBitOk;
  logic      togSame;

  nvm_poll_ctrl #(
    .WeLowCyc(WeLowCyc), .LoadGapCyc(LoadGapCyc), .PollWaitCyc(PollWaitCyc),
    .ReadCyc(ReadCyc), .TimeoutCyc(TimeoutCyc)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
    .lastByte(lastByte), .pollBitOk(pollBitOk), .togSame(togSame),
    .ctl(ctl), .reqReady(reqReady), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .memDoe(memDoe), .doneValid(doneValid), .doneErr(doneErr)
  );

  nvm_poll_datapath #(
    .AddrW(AddrW), .PageW(PageW), .DataW(DataW)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqAddr(reqAddr), .reqLen(reqLen),
    .byteData(byteData), .memDin(memDin), .memAddr(memAddr), .memDout(memDout),
    .byteIdx(byteIdx), .lastByte(lastByte), .pollBitOk(pollBitOk), .togSame(togSame)
  );

  a_r2_ready_drops: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
  a_r4_ce_with_we: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCeN);
  a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (!memWeN && !$past(reqReady)) |-> $stable(memAddr[AddrW-1:PageW]));

endmodule

// File: tb/tb_nvm_poll_writer.sv
module tb_nvm_poll_writer;
  localparam int ClkPeriod   = 10;
  localparam int WeLowCyc    = 3;
  localparam int LoadGapCyc  = 2;
  localparam int PollWaitCyc = 20;
  localparam int ReadCyc     = 3;
  localparam int TimeoutCyc  = 400;
  localparam int BusyCyc     = 60;
  localparam int Spacing     = WeLowCyc + LoadGapCyc + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [12:0] reqAddr = '0;
  logic [5:0]  reqLen = '0;
  logic        reqMode = 1'b0;
  logic [5:0]  byteIdx;
  logic [7:0]  byteData;
  logic        doneValid, doneErr;
  logic [12:0] memAddr;
  logic [7:0]  memDout, memDin;
  logic        memDoe, memCeN, memOeN, memWeN;

  int checks = 0;
  int fails = 0;
  int curTag = 0;
  logic clrStats = 1'b0;
  logic stuck = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  nvm_poll_writer #(
    .WeLowCyc(WeLowCyc), .LoadGapCyc(LoadGapCyc), .PollWaitCyc(PollWaitCyc),
    .ReadCyc(ReadCyc), .TimeoutCyc(TimeoutCyc)
  ) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqMode(reqMode), .byteIdx(byteIdx),
    .byteData(byteData), .doneValid(doneValid), .doneErr(doneErr),
    .memAddr(memAddr), .memDout(memDout), .memDin(memDin), .memDoe(memDoe),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN)
  );

  function automatic logic [7:0] dataFn(input int t, input int i);
    return 8'((t * 37 + i * 91 + 3) & 255);
  endfunction

  assign byteData = dataFn(curTag, int'(byteIdx));

  // memory model: one page buffer plus a programming window after each load
  logic [7:0]  pageBuf [64];
  logic [6:0]  pageTag = '0;
  logic [12:0] lastWrAddr = '0, curWrAddr = '0;
  logic [7:0]  lastWrData = '0, curWrData = '0;
  logic        prevWeN = 1'b1, prevOeN = 1'b1, tog = 1'b0, rdBusy = 1'b0;
  logic        firstPend = 1'b0, lastReadBusy = 1'b0;
  int busyCnt = 0, weLowLen = 0, oeLowLen = 0, sinceRise = 0, sinceFall = 0;
  int nWe = 0, nRd = 0, vWidth = 0, vSpace = 0, vCeOe = 0, vDoe = 0, vPage = 0;
  int vWait = 0, vRdAddr = 0, vRdLen = 0;

  assign memDin = rdBusy ? {~lastWrData[7], tog, pageBuf[memAddr[5:0]][5:0]}
                         : pageBuf[memAddr[5:0]];

  initial for (int i = 0; i < 64; i++) pageBuf[i] = 8'h00;

  always @(posedge clk) begin
    prevWeN <= memWeN;
    prevOeN <= memOeN;
    if (clrStats) begin
      nWe = 0; nRd = 0; vWidth = 0; vSpace = 0; vCeOe = 0; vDoe = 0;
      vPage = 0; vWait = 0; vRdAddr = 0; vRdLen = 0;
    end
    if (rstN) begin
      if (!memWeN) begin
        weLowLen  <= weLowLen + 1;
        curWrAddr <= memAddr;
        curWrData <= memDout;
        if (!memDoe) vDoe++;
        if (memCeN || !memOeN) vCeOe++;
      end else if (memDoe) vDoe++;
      if (!memOeN && memCeN) vCeOe++;
      if (!memWeN && prevWeN) begin
        if (nWe > 0 && sinceFall != Spacing) vSpace++;
        if (nWe == 0) pageTag <= memAddr[12:6];
        else if (memAddr[12:6] != pageTag) vPage++;
        nWe++;
        sinceFall <= 1;
        weLowLen  <= 1;
      end else sinceFall <= sinceFall + 1;
      if (memWeN && !prevWeN) begin
        pageBuf[curWrAddr[5:0]] <= curWrData;
        lastWrAddr <= curWrAddr;
        lastWrData <= curWrData;
        busyCnt    <= BusyCyc;
        sinceRise  <= 0;
        firstPend  <= 1'b1;
        if (weLowLen != WeLowCyc) vWidth++;
      end else begin
        if (busyCnt > 0) busyCnt <= busyCnt - 1;
        sinceRise <= sinceRise + 1;
      end
      if (!memOeN && prevOeN) begin
        nRd++;
        tog      <= ~tog;
        rdBusy   <= (busyCnt != 0) || stuck;
        lastReadBusy <= (busyCnt != 0) || stuck;
        oeLowLen <= 1;
        if (firstPend) begin
          if (sinceRise + 1 < PollWaitCyc) vWait++;
          firstPend <= 1'b0;
        end
        if (memAddr != lastWrAddr) vRdAddr++;
      end else if (!memOeN) oeLowLen <= oeLowLen + 1;
      if (memOeN && !prevOeN && oeLowLen != ReadCyc) vRdLen++;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_req(input int page, input int off, input int cnt, input int mode,
                         output logic err, output int cyc);
    @(negedge clk); clrStats = 1'b1;
    @(negedge clk); clrStats = 1'b0;
    reqAddr  = 13'(page * 64 + off);
    reqLen   = 6'(cnt - 1);
    reqMode  = mode[0];
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(reqReady == 1'b0, "R2", int'(reqReady), 0);
    cyc = 0;
    while (!doneValid && cyc < 5000) begin
      @(negedge clk);
      cyc++;
    end
    err = doneErr;
    chk(doneValid == 1'b1, "R11", int'(doneValid), 1);
    @(negedge clk);
    chk(doneValid == 1'b0, "R11", int'(doneValid), 0);
    chk(reqReady == 1'b1, "R2", int'(reqReady), 1);
  endtask

  task automatic check_burst(input int page, input int off, input int cnt, input int mode,
                             input logic err);
    chk(err == 1'b0, "R11", int'(err), 0);
    chk(nWe == cnt, "R3", nWe, cnt);
    chk(int'(pageTag) == page, "R3", int'(pageTag), page);
    for (int i = 0; i < cnt; i++)
      chk(pageBuf[(off + i) % 64] == dataFn(curTag, i), "R3",
          int'(pageBuf[(off + i) % 64]), int'(dataFn(curTag, i)));
    chk(vWidth == 0 && vSpace == 0, "R4", vWidth + vSpace, 0);
    chk(vDoe == 0 && vCeOe == 0, "R5", vDoe + vCeOe, 0);
    chk(vWait == 0, "R6", vWait, 0);
    chk(vRdAddr == 0 && vRdLen == 0 && nRd >= 1, "R7", vRdAddr + vRdLen, 0);
    if (mode == 0) chk(lastReadBusy == 1'b0, "R8", int'(lastReadBusy), 0);
    else begin
      chk(lastReadBusy == 1'b0, "R9", int'(lastReadBusy), 0);
      chk(nRd >= 2, "R9", nRd, 2);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    logic err;
    int cyc;
    repeat (3) @(negedge clk);
    chk(memCeN && memOeN && memWeN && !memDoe, "R1", int'({memCeN, memOeN, memWeN, memDoe}), 14);
    chk(reqReady && !doneValid, "R1", int'({reqReady, doneValid}), 2);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(memCeN && memOeN && memWeN && !memDoe, "R1", int'({memCeN, memOeN, memWeN, memDoe}), 14);
    chk(reqReady && !doneValid, "R1", int'({reqReady, doneValid}), 2);

    // sweep every burst length, alternating completion method
    for (int n = 1; n <= 64; n++) begin
      int page, off, mode;
      page = (n * 5) % 128;
      off  = (n * 7) % 64;
      mode = n % 2;
      curTag = n;
      run_req(page, off, n, mode, err, cyc);
      check_burst(page, off, n, mode, err);
    end

    // wrap inside a page, both methods
    for (int m = 0; m < 2; m++) begin
      curTag = 100 + m;
      run_req(99, 60, 8, m, err, cyc);
      check_burst(99, 60, 8, m, err);
    end

    // device never finishes: R10 in both methods
    stuck = 1'b1;
    for (int m = 0; m < 2; m++) begin
      curTag = 200 + m;
      run_req(3, 5, 2, m, err, cyc);
      chk(err == 1'b1, "R10", int'(err), 1);
      chk(cyc >= TimeoutCyc && cyc <= TimeoutCyc + 60, "R10", cyc, TimeoutCyc);
    end
    stuck = 1'b0;
    curTag = 300;
    run_req(7, 0, 4, 0, err, cyc);
    check_burst(7, 0, 4, 0, err);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule